// File: doc/BRIEF.md
# Prescaled Alarm Timer Group

This block holds a small set of identical general-purpose timers behind one word-wide register port, with a shared interrupt status word and a single level interrupt output. Each timer owns a wide counter that advances on ticks from its own programmable clock divider. Software can count up or down, pause and resume, and load any value. A per-timer alarm comparator raises that timer's status bit when the counter steps onto the alarm value. On that same edge the counter can optionally be reloaded from a separate reload register.

Software configures a timer by writing its control word. It loads the counter by writing the low staging half and then the high half. It arms the alarm, which fires once and then disarms itself. The interrupt is then serviced through the group's enable, write-one-to-clear and group-initialise registers. Address bits [2:0] select the register inside a slot. The upper address bits select the slot: slot k (k < NUM_TIMERS) is timer k, and slot NUM_TIMERS is the group.

Top module: `tmr_group`

## Requirements
- R1: After reset every timer is paused, counts up, has reload off, alarm disarmed and divide field 0. Its counter, alarm and reload registers read 0, group status and enables read 0, and `irq` is low.
- R2: Timer control word (offset 0) is laid out as: bit 0 run, bit 1 count down, bit 2 auto-reload, bit 3 alarm armed, bits [31:16] divide field. While running, the counter steps once every R clocks. R equals the divide field for values 2 and above. A field of 0 gives R = 65536 and a field of 1 gives R = 2.
- R3: With bit 1 set the counter decrements once per tick, wrapping from 0 to all ones; with it clear it increments.
- R4: A paused counter holds its value. Offset 1 stages the low 32 bits of a load, and a write to offset 2 loads the whole counter at the next edge, with the staged low half under the written high half. The counter reads back exactly through offsets 1 (low) and 2 (high), and it restarts the divider phase so the first tick comes R clocks after the load.
- R5: A load takes priority over a tick that falls on the same edge.
- R6: When the armed counter steps onto the alarm value (offsets 3 low, 4 high), the timer's status bit is set and the armed bit clears on that edge. A disarmed timer never sets status.
- R7: With auto-reload on, the counter takes the reload value (offsets 5 low, 6 high) on the alarm edge instead of the alarm value. With it off, the counter continues past the alarm value.
- R8: Group offset 0 reads the raw status, with bit k for timer k. Offset 1 holds the interrupt enables. `irq` is high while any enabled status bit is set, and status is captured even when its enable is 0.
- R9: Writing 1s to group offset 2 clears the matching status bits. A status set on the same edge as a clear wins.
- R10: Writing a 1 to bit 0 of group offset 3 clears all status bits. Timer control writes and counter loads leave status untouched.
- R11: A new divide field takes effect only at the next divider rollover, or at a load.
- R12: The counter carries from its low 32 bits into its high bits as one wide value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Register address: slot in [4:3], offset in [2:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: two timers, a 64-bit counter and a 16-bit divide field. With these values the extreme divide ratio of 65536 can be timed exactly within the run, and two timers are enough to exercise independent status bits with separate enables. The 64-bit counter allows carry across the 32-bit word boundary and wrap from zero in count-down mode. Short divide ratios keep alarm, reload, load-priority and deferred-divider timings exact to the clock, and seeded random loads, directions and ratios cover the counting path.

// File: rtl/tgrp_pkg.sv
`timescale 1ns/1ps
package tgrp_pkg;
    localparam int WORD_W = 32;

    // per-timer register offsets
    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_CNT_LO = 3'd1;
    localparam logic [2:0] OFS_CNT_HI = 3'd2;
    localparam logic [2:0] OFS_ALM_LO = 3'd3;
    localparam logic [2:0] OFS_ALM_HI = 3'd4;
    localparam logic [2:0] OFS_RLD_LO = 3'd5;
    localparam logic [2:0] OFS_RLD_HI = 3'd6;

    // group register offsets
    localparam logic [2:0] GOFS_RAW  = 3'd0;
    localparam logic [2:0] GOFS_IEN  = 3'd1;
    localparam logic [2:0] GOFS_CLR  = 3'd2;
    localparam logic [2:0] GOFS_INIT = 3'd3;
    localparam logic [2:0] GOFS_PEND = 3'd4;

    // control word bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_DOWN = 1;
    localparam int CB_RLD  = 2;
    localparam int CB_ARM  = 3;
    localparam int CB_DIV  = 16;
endpackage

// File: rtl/tgrp_prescaler.sv
`timescale 1ns/1ps
module tgrp_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_field,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
        logic [DIV_W-1:0] div;
    } ps_t;

    ps_t q, d;
    logic [DIV_W-1:0] lim;

    // terminal phase: field 0 -> full range, field 1 -> behaves as 2
    always_comb begin
        if (q.div == '0)
            lim = '1;
        else if (q.div == DIV_W'(1))
            lim = DIV_W'(1);
        else
            lim = q.div - DIV_W'(1);
    end

    assign tick = run && !restart && (q.phase == lim);

    always_comb begin
        d = q;
        if (restart) begin
            d.phase = '0;
            d.div   = div_field;
        end else if (tick) begin
            d.phase = '0;
            d.div   = div_field;
        end else if (run) begin
            d.phase = q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tgrp_timer.sv
`timescale 1ns/1ps
module tgrp_timer
    import tgrp_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        ofs,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              fire
);
    localparam int HI_W = CNT_W - WORD_W;

    typedef struct packed {
        logic             run;
        logic             down;
        logic             rld;
        logic             armed;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alm;
        logic [CNT_W-1:0] rel;
        logic [WORD_W-1:0] stage;
    } tmr_t;

    tmr_t q, d;
    logic             tick;
    logic             load;
    logic [CNT_W-1:0] step;
    logic             hit;

    assign load = wr_en && (ofs == OFS_CNT_HI);
    assign step = q.down ? (q.cnt - CNT_W'(1)) : (q.cnt + CNT_W'(1));
    assign hit  = tick && q.armed && (step == q.alm);
    assign fire = hit;

    tgrp_prescaler #(.DIV_W(DIV_W)) u_ps (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (q.run),
        .restart   (load),
        .div_field (q.div),
        .tick      (tick)
    );

    always_comb begin
        d = q;
        if (tick) begin
            d.cnt = (hit && q.rld) ? q.rel : step;
            if (hit) d.armed = 1'b0;
        end
        if (wr_en) begin
            case (ofs)
                OFS_CTRL: begin
                    d.run   = wdata[CB_RUN];
                    d.down  = wdata[CB_DOWN];
                    d.rld   = wdata[CB_RLD];
                    d.armed = wdata[CB_ARM];
                    d.div   = wdata[CB_DIV +: DIV_W];
                end
                OFS_CNT_LO: d.stage = wdata;
                OFS_CNT_HI: d.cnt   = {wdata[HI_W-1:0], q.stage};
                OFS_ALM_LO: d.alm[WORD_W-1:0]     = wdata;
                OFS_ALM_HI: d.alm[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
                OFS_RLD_LO: d.rel[WORD_W-1:0]     = wdata;
                OFS_RLD_HI: d.rel[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_CTRL: begin
                rdata[CB_RUN]         = q.run;
                rdata[CB_DOWN]        = q.down;
                rdata[CB_RLD]         = q.rld;
                rdata[CB_ARM]         = q.armed;
                rdata[CB_DIV +: DIV_W] = q.div;
            end
            OFS_CNT_LO: rdata = q.cnt[WORD_W-1:0];
            OFS_CNT_HI: rdata[HI_W-1:0] = q.cnt[CNT_W-1:WORD_W];
            OFS_ALM_LO: rdata = q.alm[WORD_W-1:0];
            OFS_ALM_HI: rdata[HI_W-1:0] = q.alm[CNT_W-1:WORD_W];
            OFS_RLD_LO: rdata = q.rel[WORD_W-1:0];
            OFS_RLD_HI: rdata[HI_W-1:0] = q.rel[CNT_W-1:WORD_W];
            default: ;
        endcase
    end
endmodule

// File: rtl/tmr_group.sv
`timescale 1ns/1ps
module tmr_group
    import tgrp_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 64,
    parameter int DIV_W      = 16,
    localparam int SLOT_W    = $clog2(NUM_TIMERS + 1),
    localparam int ADDR_W    = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_TIMERS-1:0] raw;
        logic [NUM_TIMERS-1:0] ien;
    } grp_t;

    grp_t q, d;
    logic [SLOT_W-1:0]     slot;
    logic [2:0]            ofs;
    logic                  grp_wr;
    logic [NUM_TIMERS-1:0] fire_vec;
    logic [NUM_TIMERS-1:0] raw_vec;
    logic [NUM_TIMERS-1:0] ien_vec;
    logic [WORD_W-1:0]     t_rdata [NUM_TIMERS];

    assign slot   = bus_addr[ADDR_W-1:3];
    assign ofs    = bus_addr[2:0];
    assign grp_wr = bus_wr && (slot == SLOT_W'(NUM_TIMERS));

    for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_tmr
        tgrp_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && (slot == SLOT_W'(k))),
            .ofs   (ofs),
            .wdata (bus_wdata),
            .rdata (t_rdata[k]),
            .fire  (fire_vec[k])
        );
    end

    always_comb begin
        d     = q;
        d.raw = q.raw | fire_vec;
        if (grp_wr) begin
            case (ofs)
                GOFS_IEN:  d.ien = bus_wdata[NUM_TIMERS-1:0];
                GOFS_CLR:  d.raw = (q.raw & ~bus_wdata[NUM_TIMERS-1:0]) | fire_vec;
                GOFS_INIT: if (bus_wdata[0]) d.raw = '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw_vec = q.raw;
    assign ien_vec = q.ien;
    assign irq     = |(q.raw & q.ien);

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_TIMERS; k++)
            if (slot == SLOT_W'(k)) bus_rdata = t_rdata[k];
        if (slot == SLOT_W'(NUM_TIMERS)) begin
            case (ofs)
                GOFS_RAW:  bus_rdata[NUM_TIMERS-1:0] = q.raw;
                GOFS_IEN:  bus_rdata[NUM_TIMERS-1:0] = q.ien;
                GOFS_PEND: bus_rdata[NUM_TIMERS-1:0] = q.raw & q.ien;
                default: ;
            endcase
        end
    end
endmodule

module tmr_group_chk #(
    parameter int N      = 2,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      wlow,
    input logic              wbit0,
    input logic [N-1:0]      fire,
    input logic [N-1:0]      raw,
    input logic [N-1:0]      ien,
    input logic              irq
);
    logic grp_sel, clr_wr, init_wr;
    assign grp_sel = bus_wr && (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(N));
    assign clr_wr  = grp_sel && (bus_addr[2:0] == 3'd2);
    assign init_wr = grp_sel && (bus_addr[2:0] == 3'd3) && wbit0;

    // R6 / R8: an alarm always lands in the status word
    a_r8_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire && !init_wr) |=> ((raw & $past(fire)) == $past(fire)));

    // R9: clearing with no concurrent alarm empties the selected bits
    a_r9_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && fire == '0) |=> ((raw & $past(wlow)) == '0));

    // R10: group initialisation empties the status word
    a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (raw == '0));

    // R8: no interrupt without an enable
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R10: status changes only through alarms or group writes
    a_r10_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && fire == '0) |=> (raw == $past(raw)));
endmodule

bind tmr_group tmr_group_chk #(.N(NUM_TIMERS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wlow     (bus_wdata[NUM_TIMERS-1:0]),
    .wbit0    (bus_wdata[0]),
    .fire     (fire_vec),
    .raw      (raw_vec),
    .ien      (ien_vec),
    .irq      (irq)
);

// File: tb/tmr_group_test.sv
`timescale 1ns/1ps
module tmr_group_test;
    localparam int G = 2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_group uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] ctrl(bit run, bit down, bit rld, bit arm, int div);
        logic [31:0] v = '0;
        v[0] = run; v[1] = down; v[2] = rld; v[3] = arm;
        v[31:16] = div[15:0];
        return v;
    endfunction

    function automatic int ratio_of(int field);
        if (field == 0) return 65536;
        if (field == 1) return 2;
        return field;
    endfunction

    function automatic logic [63:0] model_cnt(logic [63:0] start, bit down, int k);
        return down ? start - 64'(k) : start + 64'(k);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // caller is at a negedge; the write lands on the next posedge
    task automatic wr(int slot, int ofs, logic [31:0] data);
        bus_addr = 5'((slot << 3) | ofs);
        bus_wdata = data;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int slot, int ofs, output logic [31:0] v);
        bus_addr = 5'((slot << 3) | ofs);
        #0.2;
        v = bus_rdata;
    endtask

    task automatic rd64(int slot, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(slot, 1, lo);
        rd(slot, 2, hi);
        v = {hi, lo};
    endtask

    task automatic ld(int slot, logic [63:0] v);
        wr(slot, 1, v[31:0]);
        wr(slot, 2, v[63:32]);
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [63:0] c, c2;
        void'($urandom(32'd4242));
        waitn(2);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state
        rd(0, 0, w);  chk("R1 ctrl", w, 0);
        rd64(0, c);   chk("R1 count", c, 0);
        rd(1, 3, w);  chk("R1 alarm", w, 0);
        rd(G, 0, w);  chk("R1 status", w, 0);
        chk("R1 irq", irq, 0);

        // R4 paused load and readback
        wr(0, 0, ctrl(0,0,0,0,4));
        ld(0, 64'h30405000);
        rd64(0, c);  chk("R4 load readback", c, 64'h30405000);
        waitn(20);
        rd64(0, c);  chk("R4 paused hold", c, 64'h30405000);
        wr(0, 0, ctrl(1,0,0,0,4));
        waitn(8);
        rd64(0, c);  chk("R4 resumes", c, 64'h30405002);

        // R12 carry across word boundary
        wr(0, 0, ctrl(0,0,0,0,2));
        ld(0, 64'hFFFF_FFFF);
        wr(0, 0, ctrl(1,0,0,0,2));
        waitn(2);
        rd64(0, c);  chk("R12 carry", c, 64'h1_0000_0000);

        // R3 count down and wrap
        wr(1, 0, ctrl(0,1,0,0,3));
        ld(1, 64'd10);
        wr(1, 0, ctrl(1,1,0,0,3));
        waitn(9);
        rd64(1, c);  chk("R3 down", c, 64'd7);
        wr(1, 0, ctrl(0,1,0,0,2));
        ld(1, 64'd1);
        wr(1, 0, ctrl(1,1,0,0,2));
        waitn(4);
        rd64(1, c);  chk("R3 wrap", c, 64'hFFFF_FFFF_FFFF_FFFF);

        // R5 load on a tick edge
        wr(0, 0, ctrl(0,0,0,0,2));
        ld(0, 0);
        wr(0, 0, ctrl(1,0,0,0,2));
        wr(0, 1, 32'h1000);
        wr(0, 2, 32'h0);
        rd64(0, c);  chk("R5 load wins", c, 64'h1000);
        waitn(1);
        rd64(0, c);  chk("R5 phase restart", c, 64'h1000);
        waitn(1);
        rd64(0, c);  chk("R5 first tick", c, 64'h1001);

        // R11 deferred divider change
        wr(0, 0, ctrl(0,0,0,0,4));
        ld(0, 0);
        wr(0, 0, ctrl(1,0,0,0,4));
        waitn(4);
        wr(0, 0, ctrl(1,0,0,0,2));
        waitn(2);
        rd64(0, c);  chk("R11 old ratio kept", c, 64'd1);
        waitn(3);
        rd64(0, c);  chk("R11 new ratio", c, 64'd3);

        // R2 field 1 behaves as 2
        wr(0, 0, ctrl(0,0,0,0,1));
        ld(0, 0);
        wr(0, 0, ctrl(1,0,0,0,1));
        waitn(6);
        rd64(0, c);  chk("R2 field1", c, 64'd3);

        // R6 R7 R8 alarm on timer 0, no reload, enabled
        wr(0, 0, ctrl(0,0,0,0,2));
        ld(0, 0);
        wr(0, 3, 32'd5);
        wr(0, 4, 32'd0);
        wr(G, 1, 32'd1);
        wr(0, 0, ctrl(1,0,0,1,2));
        waitn(9);
        rd(G, 0, w);  chk("R6 before alarm", w, 0);
        chk("R8 irq before", irq, 0);
        waitn(1);
        rd(G, 0, w);  chk("R6 status set", w, 1);
        chk("R8 irq high", irq, 1);
        rd(0, 0, w);  chk("R6 self disarm", w[3], 0);
        rd64(0, c);   chk("R7 no reload value", c, 64'd5);
        waitn(2);
        rd64(0, c);   chk("R7 runs past", c, 64'd6);
        wr(G, 2, 32'd1);
        rd(G, 0, w);  chk("R9 clear", w, 0);
        chk("R9 irq low", irq, 0);

        // R6 disarmed timer 1 never fires
        wr(1, 0, ctrl(0,0,0,0,2));
        ld(1, 0);
        wr(1, 3, 32'd3);
        wr(1, 4, 32'd0);
        wr(G, 1, 32'd3);
        wr(1, 0, ctrl(1,0,0,0,2));
        waitn(10);
        rd64(1, c);   chk("R6 passed alarm", c, 64'd5);
        rd(G, 0, w);  chk("R6 disarmed no status", w, 0);
        chk("R6 irq low", irq, 0);
        wr(1, 0, ctrl(0,0,0,0,2));

        // R9 set wins over a clear on the same edge
        wr(0, 0, ctrl(0,0,0,0,2));
        ld(0, 0);
        wr(0, 3, 32'd2);
        wr(0, 0, ctrl(1,0,0,1,2));
        waitn(3);
        wr(G, 2, 32'd1);
        rd(G, 0, w);  chk("R9 set wins", w, 1);
        wr(G, 2, 32'd1);
        rd(G, 0, w);  chk("R9 cleared after", w, 0);
        wr(0, 0, ctrl(0,0,0,0,2));

        // R7 reload, R8 capture without enable, R10
        wr(G, 1, 32'd0);
        wr(1, 0, ctrl(0,0,1,0,2));
        ld(1, 0);
        wr(1, 3, 32'd3);
        wr(1, 5, 32'd100);
        wr(1, 6, 32'd0);
        wr(1, 0, ctrl(1,0,1,1,2));
        waitn(5);
        rd64(1, c);   chk("R7 before reload", c, 64'd2);
        waitn(1);
        rd64(1, c);   chk("R7 reloaded", c, 64'd100);
        rd(G, 0, w);  chk("R8 captured", w, 2);
        chk("R8 irq masked", irq, 0);
        wr(G, 1, 32'd2);
        chk("R8 irq enabled", irq, 1);
        rd(G, 4, w);  chk("R8 pending", w, 2);
        wr(1, 0, ctrl(0,0,0,0,2));
        ld(1, 64'd7);
        rd(G, 0, w);  chk("R10 survives reconfig", w, 2);
        wr(G, 3, 32'd1);
        rd(G, 0, w);  chk("R10 init clears", w, 0);
        chk("R10 irq low", irq, 0);

        // R2 R3 seeded random counting
        for (int t = 0; t < 12; t++) begin
            int slot = int'($urandom_range(1, 0));
            int fld = int'($urandom_range(6, 1));
            bit dn = 1'($urandom_range(1, 0));
            int k = int'($urandom_range(8, 1));
            logic [63:0] st = {$urandom, $urandom};
            wr(slot, 0, ctrl(0, dn, 0, 0, fld));
            ld(slot, st);
            wr(slot, 0, ctrl(1, dn, 0, 0, fld));
            waitn(k * ratio_of(fld));
            rd64(slot, c2);
            chk("R2 R3 random", c2, model_cnt(st, dn, k));
            wr(slot, 0, ctrl(0, dn, 0, 0, fld));
        end

        // R2 field 0 is the full ratio
        wr(0, 0, ctrl(0,0,0,0,0));
        ld(0, 0);
        wr(0, 0, ctrl(1,0,0,0,0));
        waitn(65535);
        rd64(0, c);  chk("R2 field0 before", c, 0);
        waitn(1);
        rd64(0, c);  chk("R2 field0 tick", c, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule